// File: doc/BRIEF.md
# Embedded Controller Host Mailbox

This block is the controller side of a byte-wide mailbox that a host reaches through two port locations: a data port and a command port. The command port reads back as a status byte. The host writes a command byte, then address and data bytes, and it polls two flow-control flags between bytes. The input-full flag means a written byte is still waiting to be taken. The output-full flag means a reply byte is ready to be read.

An internal sequencer takes each host byte a fixed number of cycles after it arrives. It decodes the byte and drives a synchronous register-file port, so the host can read and write a 256-entry byte register space. The sequencer also handles burst enable and burst disable, and it handles a query command that hands out the lowest pending event from an event mask.

Top module: `ec_mailbox`

## Requirements
- R1: `hst_sel_cmd`=0 selects the data port and `hst_sel_cmd`=1 selects the command/status port. The status byte has output-full at bit 0, input-full at bit 1, last-write-was-command at bit 3 and burst-active at bit 4. All other bits read 0. After reset the status byte is 0x00.
- R2: A host write to either port sets input-full at the next clock edge and latches the byte. Bit 3 records which port was written. Input-full clears exactly `CONSUME_LAT` cycles after the write edge.
- R3: Command 0x80 followed by an address byte causes exactly one register read. The returned byte is placed in the output buffer and output-full is set.
- R4: Command 0x81 followed by an address byte and then a data byte causes exactly one register write of that data at that address.
- R5: A host read of the data port returns the output buffer and clears output-full.
- R6: Command 0x82 sets burst-active and places 0x90 in the output buffer with output-full set. Command 0x83 clears burst-active and produces no reply.
- R7: Command 0x84 replies with (index+1) of the lowest set bit of the pending mask and clears that bit. It replies with 0 when no bit is set. A pulse on `evt_set` sets bits in the mask.
- R8: An unknown command code returns the sequencer to idle without a register access or a reply. A data byte that arrives while idle is also ignored.
- R9: A command byte written in the middle of a sequence abandons that sequence and starts the new one.
- R10: Register read data is taken one cycle after `reg_re`. `reg_re` and `reg_we` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_sel_cmd | input | 1 | 1 = command/status port, 0 = data port |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Status byte or output buffer, selected by `hst_sel_cmd` |
| evt_set | input | EVW | Pulses that set pending event bits |
| reg_re | output | 1 | Register read strobe |
| reg_we | output | 1 | Register write strobe |
| reg_addr | output | 8 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data, valid one cycle after `reg_re` |

## Verification
The hardest situation to reach is a sequence that is cut short. This covers a new command arriving after a write command has already taken its address, and it also covers a data byte that arrives while the sequencer is idle. The bench reaches these cases by driving the host polling loop byte by byte and inserting the interrupting byte at chosen points. It counts every register strobe and compares memory contents against a reference array, so a stray write or read is exposed.

// File: rtl/ec_mailbox.sv
module ec_mailbox #(
  parameter int CONSUME_LAT = 1,
  parameter int EVW         = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hst_wr,
  input  logic           hst_rd,
  input  logic           hst_sel_cmd,
  input  logic [7:0]     hst_wdata,
  output logic [7:0]     hst_rdata,
  input  logic [EVW-1:0] evt_set,
  output logic           reg_re,
  output logic           reg_we,
  output logic [7:0]     reg_addr,
  output logic [7:0]     reg_wdata,
  input  logic [7:0]     reg_rdata
);
  localparam int CW = $clog2(CONSUME_LAT + 1);
  localparam logic [7:0] C_RD = 8'h80, C_WR = 8'h81, C_BE = 8'h82,
                         C_BD = 8'h83, C_QR = 8'h84, BURST_ACK = 8'h90;

  typedef enum logic [2:0] {S_IDLE, S_RADDR, S_RWAIT, S_WADDR, S_WDATA} st_t;

  st_t            st;
  logic           ibf, obf, cflag, burst;
  logic [7:0]     ibuf, obuf, waddr;
  logic [CW-1:0]  cnt;
  logic [EVW-1:0] pend, q_clr;
  logic [7:0]     q_num;

  wire take     = ibf && (cnt == '0) && (st != S_RWAIT) && !hst_wr;
  wire take_cmd = take && cflag;
  wire take_dat = take && !cflag;
  wire do_query = take_cmd && (ibuf == C_QR);
  wire do_burst = take_cmd && (ibuf == C_BE);

  assign hst_rdata = hst_sel_cmd ? {3'b000, burst, cflag, 1'b0, ibf, obf} : obuf;
  assign reg_re    = take_dat && (st == S_RADDR);
  assign reg_we    = take_dat && (st == S_WDATA);
  assign reg_addr  = (st == S_WDATA) ? waddr : ibuf;
  assign reg_wdata = ibuf;

  always_comb begin
    q_num = 8'h00;
    q_clr = '0;
    for (int i = EVW - 1; i >= 0; i--) begin
      if (pend[i]) begin
        q_num    = 8'(i + 1);
        q_clr    = '0;
        q_clr[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ibf <= 1'b0; cflag <= 1'b0; ibuf <= 8'h00; cnt <= '0;
    end else if (hst_wr) begin
      ibf <= 1'b1; cflag <= hst_sel_cmd; ibuf <= hst_wdata;
      cnt <= CW'(CONSUME_LAT - 1);
    end else if (take) begin
      ibf <= 1'b0;
    end else if (ibf && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; waddr <= 8'h00; burst <= 1'b0;
      obf <= 1'b0; obuf <= 8'h00; pend <= '0;
    end else begin
      pend <= (pend | evt_set) & ~(do_query ? q_clr : '0);
      if (hst_rd && !hst_sel_cmd) obf <= 1'b0;
      if (st == S_RWAIT) begin
        obuf <= reg_rdata; obf <= 1'b1; st <= S_IDLE;
      end else if (take_cmd) begin
        st <= S_IDLE;
        case (ibuf)
          C_RD: st <= S_RADDR;
          C_WR: st <= S_WADDR;
          C_BE: begin burst <= 1'b1; obuf <= BURST_ACK; obf <= 1'b1; end
          C_BD: burst <= 1'b0;
          C_QR: begin obuf <= q_num; obf <= 1'b1; end
          default: ;
        endcase
      end else if (take_dat) begin
        case (st)
          S_RADDR: st <= S_RWAIT;
          S_WADDR: begin waddr <= ibuf; st <= S_WDATA; end
          S_WDATA: st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R2
  wr_sets_ibf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hst_wr |=> ibf);
  // R10
  reg_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_re, reg_we}));
  // R3
  read_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> ##1 obf);
  // R5
  rd_clears_obf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_rd && !hst_sel_cmd && st != S_RWAIT && !take_cmd) |=> !obf);
  // R6
  burst_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_burst |=> (burst && obf && obuf == BURST_ACK));
  // R2
  take_clears_ibf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !ibf);
endmodule

// File: tb/ec_mailbox_tb.sv
module ec_mailbox_tb;
  localparam int LAT = 3;
  localparam int EVW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hst_wr = 1'b0, hst_rd = 1'b0, hst_sel_cmd = 1'b0;
  logic [7:0] hst_wdata = 8'h00, hst_rdata;
  logic [EVW-1:0] evt_set = '0;
  logic reg_re, reg_we;
  logic [7:0] reg_addr, reg_wdata;
  logic [7:0] reg_rdata = 8'h00;
  logic [7:0] mem [256];
  logic [7:0] refm [256];
  int n_chk = 0, n_bad = 0, n_acc = 0, cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ec_mailbox #(.CONSUME_LAT(LAT), .EVW(EVW)) u_dut (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd),
    .hst_sel_cmd(hst_sel_cmd), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .evt_set(evt_set), .reg_re(reg_re), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  always @(posedge clk) begin
    if (reg_we) mem[reg_addr] <= reg_wdata;
    if (reg_re) reg_rdata <= mem[reg_addr];
    if (rst_n && (reg_we || reg_re)) n_acc <= n_acc + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] status();
    return u_dut.hst_rdata;
  endfunction

  task automatic peek_status(output logic [7:0] s);
    hst_sel_cmd = 1'b1; #0;
    s = hst_rdata;
  endtask

  task automatic hwrite(input logic sel, input logic [7:0] b);
    @(negedge clk);
    hst_wr = 1'b1; hst_sel_cmd = sel; hst_wdata = b;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic wait_ibf(input string req);
    logic [7:0] s;
    int n = 0;
    peek_status(s);
    while (s[1] && n < 500) begin
      @(negedge clk); n++; peek_status(s);
    end
    chk(req, s[1], 0);
  endtask

  task automatic wait_obf(input string req);
    logic [7:0] s;
    int n = 0;
    peek_status(s);
    while (!s[0] && n < 500) begin
      @(negedge clk); n++; peek_status(s);
    end
    chk(req, s[0], 1);
  endtask

  task automatic hread_data(output logic [7:0] d);
    @(negedge clk);
    hst_sel_cmd = 1'b0; hst_rd = 1'b1; #0;
    d = hst_rdata;
    @(negedge clk);
    hst_rd = 1'b0;
  endtask

  task automatic ec_write(input logic [7:0] a, input logic [7:0] d);
    wait_ibf("R4"); hwrite(1'b1, 8'h81);
    wait_ibf("R4"); hwrite(1'b0, a);
    wait_ibf("R4"); hwrite(1'b0, d);
    wait_ibf("R4");
    @(negedge clk); @(negedge clk);
    refm[a] = d;
  endtask

  task automatic ec_read(input logic [7:0] a, output logic [7:0] d);
    wait_ibf("R3"); hwrite(1'b1, 8'h80);
    wait_ibf("R3"); hwrite(1'b0, a);
    wait_obf("R3");
    hread_data(d);
  endtask

  task automatic t_reset();
    logic [7:0] s;
    peek_status(s);
    chk("R1 reset status", s, 8'h00);
    chk("R10 reset strobes", {reg_re, reg_we}, 0);
  endtask

  task automatic t_ibf_timing();
    logic [7:0] s;
    int n = 0;
    hwrite(1'b1, 8'h83);
    peek_status(s);
    chk("R2 ibf set", s[1], 1);
    chk("R1 cmd flag", s[3], 1);
    while (s[1] && n < 50) begin n++; @(negedge clk); peek_status(s); end
    chk("R2 ibf latency", n, LAT);
    hwrite(1'b0, 8'h11);
    peek_status(s);
    chk("R1 data flag", s[3], 0);
    wait_ibf("R8");
  endtask

  task automatic t_rw();
    logic [7:0] d;
    int a0;
    ec_write(8'h00, 8'hA5);
    ec_write(8'h7F, 8'h3C);
    ec_write(8'hFF, 8'h5A);
    a0 = n_acc;
    ec_read(8'h7F, d); chk("R3 read 7F", d, refm[8'h7F]);
    chk("R10 one access per read", n_acc - a0, 1);
    ec_read(8'hFF, d); chk("R3 read FF", d, refm[8'hFF]);
    ec_read(8'h00, d); chk("R4 read 00", d, refm[8'h00]);
    chk("R4 mem direct", mem[8'h7F], 8'h3C);
  endtask

  task automatic t_obf_clear();
    logic [7:0] s;
    peek_status(s);
    chk("R5 obf cleared", s[0], 0);
  endtask

  task automatic t_burst();
    logic [7:0] s, d;
    wait_ibf("R6"); hwrite(1'b1, 8'h82);
    wait_obf("R6");
    peek_status(s);
    chk("R6 burst flag", s[4], 1);
    hread_data(d);
    chk("R6 ack", d, 8'h90);
    wait_ibf("R6"); hwrite(1'b1, 8'h83); wait_ibf("R6");
    @(negedge clk); peek_status(s);
    chk("R6 burst off", s[4], 0);
    chk("R6 no reply", s[0], 0);
  endtask

  task automatic qry(output logic [7:0] d);
    wait_ibf("R7"); hwrite(1'b1, 8'h84); wait_obf("R7"); hread_data(d);
  endtask

  task automatic t_query();
    logic [7:0] d;
    @(negedge clk); evt_set = 8'b0010_0100;
    @(negedge clk); evt_set = '0;
    qry(d); chk("R7 first", d, 3);
    qry(d); chk("R7 second", d, 6);
    qry(d); chk("R7 empty", d, 0);
  endtask

  task automatic t_unknown();
    logic [7:0] s;
    int a0 = n_acc;
    wait_ibf("R8"); hwrite(1'b1, 8'h55);
    wait_ibf("R8"); hwrite(1'b0, 8'h20);
    wait_ibf("R8"); hwrite(1'b0, 8'hEE);
    wait_ibf("R8");
    repeat (4) @(negedge clk);
    chk("R8 no access", n_acc - a0, 0);
    peek_status(s);
    chk("R8 no reply", s[0], 0);
  endtask

  task automatic t_restart();
    logic [7:0] d;
    int a0;
    wait_ibf("R9"); hwrite(1'b1, 8'h81);
    wait_ibf("R9"); hwrite(1'b0, 8'h10);
    a0 = n_acc;
    ec_read(8'h10, d);
    chk("R9 single access", n_acc - a0, 1);
    chk("R9 old value", d, refm[8'h10]);
    chk("R9 mem untouched", mem[8'h10], refm[8'h10]);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 1);
      refm[i] = 8'(i * 7 + 1);
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_ibf_timing();
    t_rw();
    t_obf_clear();
    t_burst();
    t_query();
    t_unknown();
    t_restart();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule